// File: doc/BRIEF.md
# P-224 Final Reducer

This block finishes modular reduction for the 224-bit prime p = 2^224 − 2^96 + 1. Its input is a 256-bit value held as eight 32-bit limbs. An earlier folding step has made that value non-negative, congruent to a product modulo p, and below 2^226 + 2^192. The block returns an equivalent value in the redundant range [0, 2^224). Results in that range can go straight back into further multiplications.

The block takes the multiple count t from the top 32-bit word of the input. Because of the input range, t lies in 0..4. The block builds t·p limb by limb from t using masks, with no table, and subtracts it in one pass. The output can still reach 2^224 or above. That happens only when the low 224 bits sit close to the top of their range, and then one more subtraction of p is applied and reported on a flag. When the caller asks for full reduction, a final compare-and-select subtraction of p brings the value into [0, p).

The block is a two-stage pipeline. It accepts a new value on every cycle that `in_valid` is high, and each result appears two cycles later with a `done` strobe.

Top module: `p224_final_reducer`

## Requirements
- R1: `done` is high exactly two clock cycles after a cycle in which `in_valid` was high, and low two cycles after a cycle in which `in_valid` was low.
- R2: With `full_mode` low, `result` is congruent to `in_word` modulo p and lies in [0, 2^224).
- R3: The multiple count t is `in_word[255:224]` (0..4). When t = 0 and `full_mode` is low, `result` equals `in_word[223:0]` unchanged and `extra_sub` is 0.
- R4: Let L = `in_word[223:0]`. If L + t·(2^96 − 1) < 2^224, then `result` equals L + t·(2^96 − 1) in redundant mode, and `extra_sub` is 0.
- R5: If L + t·(2^96 − 1) ≥ 2^224, then `extra_sub` is 1 and `result` equals L + t·(2^96 − 1) − p in redundant mode. This value is below 5·2^96.
- R6: With `full_mode` high, `result` equals `in_word` mod p, so it is below p. This holds for every t and with or without the extra subtraction.
- R7: In full mode, a value already below p passes through unchanged. A value in [p, 2^224) has p subtracted once.
- R8: While reset is held and after it is released, before any input, `done`, `extra_sub` and `result` are all zero.
- R9: `extra_sub` is high only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input value present this cycle |
| full_mode | input | 1 | 1: reduce fully into [0, p); 0: stop at [0, 2^224) |
| in_word | input | 256 | Partially reduced value, eight 32-bit limbs, limb 0 least significant |
| done | output | 1 | Result valid strobe |
| extra_sub | output | 1 | The rare second subtraction of p was applied to this result |
| result | output | 224 | Reduced value |

## Verification
Every result, and the extra-subtraction flag, is due on the second rising edge after the edge that captured `in_valid`. No result is due earlier, and `done` must stay low on the edge in between. The bench drives each input at a falling edge and drops `in_valid` at the next falling edge, where it checks that `done` is still low. It samples `result`, `done` and `extra_sub` at the falling edge after that. Every check therefore falls half a cycle after the edge on which the value was registered. The clocked properties use the same two-cycle offset to relate each input to its output.

// File: rtl/p224_red_pkg.sv
package p224_red_pkg;
   localparam int unsigned LIMB_W    = 32;
   localparam int unsigned NUM_LIMBS = 8;
   localparam int unsigned WORD_W    = LIMB_W * NUM_LIMBS;
   localparam int unsigned RES_W     = WORD_W - LIMB_W;
   localparam int unsigned T_W       = 3;
   localparam logic [255:0] P224_VAL =
      (256'd1 << 224) - (256'd1 << 96) + 256'd1;
endpackage

// File: rtl/p224_multiple_gen.sv
module p224_multiple_gen #(
   parameter int unsigned LIMB_W    = 32,
   parameter int unsigned NUM_LIMBS = 8,
   parameter int unsigned T_W       = 3
) (
   input  logic [T_W-1:0]              t,
   output logic [LIMB_W*NUM_LIMBS-1:0] mult
);
   logic              nz;
   logic [LIMB_W-1:0] t_ext;
   logic [LIMB_W-1:0] mask;

   assign nz    = |t;
   assign t_ext = LIMB_W'(t);
   assign mask  = {LIMB_W{nz}};

   for (genvar i = 0; i < NUM_LIMBS; i++) begin : g_limb
      if (i == 0) begin : g_low
         assign mult[i*LIMB_W +: LIMB_W] = t_ext;
      end else if (i == 1 || i == 2) begin : g_zero
         assign mult[i*LIMB_W +: LIMB_W] = '0;
      end else if (i == 3) begin : g_neg
         assign mult[i*LIMB_W +: LIMB_W] = '0 - t_ext;
      end else if (i == NUM_LIMBS - 1) begin : g_top
         assign mult[i*LIMB_W +: LIMB_W] = (t_ext - LIMB_W'(1)) & mask;
      end else begin : g_ones
         assign mult[i*LIMB_W +: LIMB_W] = mask;
      end
   end
endmodule

// File: rtl/p224_limb_sub.sv
module p224_limb_sub #(
   parameter int unsigned LIMB_W    = 32,
   parameter int unsigned NUM_LIMBS = 8
) (
   input  logic [LIMB_W*NUM_LIMBS-1:0] a,
   input  logic [LIMB_W*NUM_LIMBS-1:0] b,
   output logic [LIMB_W*NUM_LIMBS-1:0] diff,
   output logic                        borrow_out
);
   logic [NUM_LIMBS:0] br;

   assign br[0] = 1'b0;

   for (genvar i = 0; i < NUM_LIMBS; i++) begin : g_limb
      logic [LIMB_W:0] part;
      assign part = {1'b0, a[i*LIMB_W +: LIMB_W]}
                  - {1'b0, b[i*LIMB_W +: LIMB_W]}
                  - (LIMB_W+1)'(br[i]);
      assign diff[i*LIMB_W +: LIMB_W] = part[LIMB_W-1:0];
      assign br[i+1] = part[LIMB_W];
   end

   assign borrow_out = br[NUM_LIMBS];
endmodule

// File: rtl/p224_correct_stage.sv
module p224_correct_stage
   import p224_red_pkg::*;
#(
   parameter int unsigned LIMB_W     = 32,
   parameter int unsigned NUM_LIMBS  = 8,
   parameter bit          FULL_STAGE = 1'b1
) (
   input  logic [LIMB_W*NUM_LIMBS-1:0]          r1,
   input  logic                                 full_mode,
   output logic [LIMB_W*NUM_LIMBS-LIMB_W-1:0]   res,
   output logic                                 extra
);
   localparam int unsigned W_W = LIMB_W * NUM_LIMBS;
   localparam int unsigned R_W = W_W - LIMB_W;
   localparam logic [W_W-1:0] PMOD = W_W'(P224_VAL);

   logic [W_W-1:0] sub_b;
   logic [W_W-1:0] r2;
   logic           unused_br_fix;

   assign extra = |r1[W_W-1:R_W];
   assign sub_b = PMOD & {W_W{extra}};

   p224_limb_sub #(.LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS)) u_fix (
      .a(r1), .b(sub_b), .diff(r2), .borrow_out(unused_br_fix)
   );

   if (FULL_STAGE) begin : g_full
      logic [W_W-1:0] d;
      logic           brw;
      logic           take;
      logic [W_W-1:0] unused_hi;
      p224_limb_sub #(.LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS)) u_cmp (
         .a(r2), .b(PMOD), .diff(d), .borrow_out(brw)
      );
      assign take      = full_mode & ~brw;
      assign res       = take ? d[R_W-1:0] : r2[R_W-1:0];
      assign unused_hi = {d[W_W-1:R_W], r2[W_W-1:R_W], {R_W{1'b0}}};
   end else begin : g_redundant
      logic [W_W-R_W:0] unused_hi;
      assign res       = r2[R_W-1:0];
      assign unused_hi = {full_mode, r2[W_W-1:R_W]};
   end
endmodule

// File: rtl/p224_final_reducer.sv
module p224_final_reducer
   import p224_red_pkg::*;
#(
   parameter int unsigned LIMB_W     = 32,
   parameter int unsigned NUM_LIMBS  = 8,
   parameter int unsigned T_W        = 3,
   parameter bit          FULL_STAGE = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  in_valid,
   input  logic                                  full_mode,
   input  logic [LIMB_W*NUM_LIMBS-1:0]           in_word,
   output logic                                  done,
   output logic                                  extra_sub,
   output logic [LIMB_W*NUM_LIMBS-LIMB_W-1:0]    result
);
   localparam int unsigned W_W = LIMB_W * NUM_LIMBS;
   localparam int unsigned R_W = W_W - LIMB_W;

   if (LIMB_W != 32) begin : g_bad_limb
      $error("p224_final_reducer: multiple rules need 32-bit limbs");
   end
   if (NUM_LIMBS != 8) begin : g_bad_count
      $error("p224_final_reducer: eight limbs are required");
   end
   if (T_W < 3 || T_W > LIMB_W) begin : g_bad_t
      $error("p224_final_reducer: count field must hold 0..4");
   end

   logic [T_W-1:0]       t;
   logic [W_W-1:0]       mult;
   logic [W_W-1:0]       r1;
   logic                 unused_br_main;
   logic [W_W-R_W-T_W-1:0] unused_top;

   assign t          = in_word[R_W +: T_W];
   assign unused_top = in_word[W_W-1:R_W+T_W];

   p224_multiple_gen #(.LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS), .T_W(T_W)) u_gen (
      .t(t), .mult(mult)
   );

   p224_limb_sub #(.LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS)) u_main (
      .a(in_word), .b(mult), .diff(r1), .borrow_out(unused_br_main)
   );

   logic           s1_valid;
   logic           s1_mode;
   logic [W_W-1:0] s1_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_mode  <= 1'b0;
         s1_val   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_mode <= full_mode;
            s1_val  <= r1;
         end
      end
   end

   logic [R_W-1:0] res_c;
   logic           extra_c;

   p224_correct_stage #(
      .LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS), .FULL_STAGE(FULL_STAGE)
   ) u_fix (
      .r1(s1_val), .full_mode(s1_mode), .res(res_c), .extra(extra_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         extra_sub <= 1'b0;
         result    <= '0;
      end else begin
         done      <= s1_valid;
         extra_sub <= s1_valid & extra_c;
         if (s1_valid) begin
            result <= res_c;
         end
      end
   end
endmodule

// File: rtl/p224_final_reducer_chk.sv
module p224_final_reducer_chk
   import p224_red_pkg::*;
#(
   parameter int unsigned LIMB_W    = 32,
   parameter int unsigned NUM_LIMBS = 8
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               in_valid,
   input logic                               full_mode,
   input logic [LIMB_W*NUM_LIMBS-1:0]        in_word,
   input logic                               done,
   input logic                               extra_sub,
   input logic [LIMB_W*NUM_LIMBS-LIMB_W-1:0] result
);
   localparam int unsigned W_W = LIMB_W * NUM_LIMBS;
   localparam int unsigned R_W = W_W - LIMB_W;
   localparam logic [W_W-1:0] PMOD  = W_W'(P224_VAL);
   localparam logic [W_W-1:0] SMALL = W_W'(5) << 96;

   assert_done_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 done);

   assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !done);

   assert_zero_count_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !full_mode && in_word[W_W-1:R_W] == '0)
         |-> ##2 (result == $past(in_word[R_W-1:0], 2) && !extra_sub));

   assert_extra_small_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (extra_sub && !$past(full_mode, 2)) |-> (W_W'(result) < SMALL));

   assert_full_below_p_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && full_mode) |-> ##2 (W_W'(result) < PMOD));

   assert_extra_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      extra_sub |-> done);
endmodule

bind p224_final_reducer p224_final_reducer_chk #(
   .LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .full_mode(full_mode),
   .in_word(in_word), .done(done), .extra_sub(extra_sub), .result(result)
);

// File: tb/p224_final_reducer_test.sv
`timescale 1ns/1ps
module p224_final_reducer_test;
   localparam logic [259:0] P  = (260'd1 << 224) - (260'd1 << 96) + 260'd1;
   localparam logic [259:0] K  = (260'd1 << 96) - 260'd1;
   localparam logic [259:0] TOP = 260'd1 << 224;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         full_mode = 1'b0;
   logic [255:0] in_word = '0;
   logic         done;
   logic         extra_sub;
   logic [223:0] result;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   p224_final_reducer uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .full_mode(full_mode),
      .in_word(in_word), .done(done), .extra_sub(extra_sub), .result(result)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [259:0] act, input logic [259:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Value after the single multiple subtraction, from the R4/R5 formula.
   function automatic logic [259:0] after_main(input logic [259:0] x);
      return (x & (TOP - 1)) + (x >> 224) * K;
   endfunction

   logic [259:0] got;
   logic         got_done, got_extra;

   task automatic apply(input logic [259:0] x, input bit mode);
      @(negedge clk);
      in_word   = x[255:0];
      full_mode = mode;
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(done == 1'b0, "R1 done early", 260'(done), 260'd0);
      @(negedge clk);
      got       = 260'(result);
      got_done  = done;
      got_extra = extra_sub;
      chk(got_done == 1'b1, "R1 done late", 260'(got_done), 260'd1);
   endtask

   task automatic check_generic(input logic [259:0] x, input bit mode);
      logic [259:0] r1;
      logic         exp_extra;
      r1 = after_main(x);
      exp_extra = (r1 >= TOP);
      chk(got_extra == exp_extra, "R5 extra flag", 260'(got_extra), 260'(exp_extra));
      if (mode) begin
         chk(got == x % P, "R6 full value", got, x % P);
      end else begin
         chk(got % P == x % P && got < TOP, "R2 congruent/range", got % P, x % P);
         chk(got == (exp_extra ? r1 - P : r1), "R4 redundant value", got,
             exp_extra ? r1 - P : r1);
      end
   endtask

   initial begin
      #(5.0 * 100000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [259:0] x;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(done == 0 && extra_sub == 0 && result == 0, "R8 in reset",
          {done, extra_sub, result}, 260'd0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(done == 0 && extra_sub == 0 && result == 0, "R8 after release",
          {done, extra_sub, result}, 260'd0);

      // R3: t = 0 passes the low part through
      x = TOP - 1;
      apply(x, 1'b0);
      chk(got == TOP - 1 && !got_extra, "R3 t=0 passthru", got, TOP - 1);

      // R4: t = 2, small low part
      x = (260'd2 << 224) + 260'd5;
      apply(x, 1'b0);
      chk(got == 260'd5 + 2 * K && !got_extra, "R4 t=2", got, 260'd5 + 2 * K);

      // R4: t = 4 with the largest low part the range allows
      x = (260'd4 << 224) + (260'd1 << 192) - 1;
      apply(x, 1'b0);
      chk(got == (260'd1 << 192) - 1 + 4 * K, "R4 t=4 max", got,
          (260'd1 << 192) - 1 + 4 * K);

      // R5: extra subtraction cases
      x = (260'd1 << 224) + TOP - 1;
      apply(x, 1'b0);
      chk(got == (260'd1 << 97) - 3 && got_extra, "R5 t=1 top", got, (260'd1 << 97) - 3);
      x = (260'd3 << 224) + TOP - (260'd1 << 97);
      apply(x, 1'b0);
      chk(got == (260'd1 << 97) - 4 && got_extra, "R5 t=3", got, (260'd1 << 97) - 4);

      // R7: full mode boundaries
      apply(P, 1'b1);
      chk(got == 0, "R7 x=p", got, 260'd0);
      apply(P - 1, 1'b1);
      chk(got == P - 1, "R7 x=p-1", got, P - 1);
      apply(TOP - 1, 1'b1);
      chk(got == K - 1, "R7 x=2^224-1", got, K - 1);
      // R6: full mode together with the extra subtraction
      x = (260'd1 << 224) + TOP - 1;
      apply(x, 1'b1);
      chk(got == (260'd1 << 97) - 3 && got_extra, "R6 full+extra", got,
          (260'd1 << 97) - 3);

      // Random stimulus in both modes (R2, R4, R5, R6)
      for (int n = 0; n < 400; n++) begin
         int unsigned tv;
         x = '0;
         for (int k = 0; k < 7; k++) x[k*32 +: 32] = $urandom;
         if ($urandom % 4 == 0) x[223:96] = '1;
         tv = $urandom % 5;
         if (tv == 4) x[223:192] = '0;
         if (tv == 0) x[223:192] = 32'hFFFF_FFFF;
         x[255:224] = tv;
         apply(x, n[0]);
         check_generic(x, n[0]);
      end

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule